// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an internal request bus and an external 32K x 8 asynchronous static RAM. A client presents one word request at a time: a write flag, a 15-bit word address and a write byte, qualified by a valid strobe. The block accepts the request when it signals ready. It then drives the memory's active-low chip-select, output-enable and write-strobe lines, the address bus and the data-out driver and its enable. Every phase is held for a whole number of clock cycles. That number is the ceiling of the memory's minimum time window divided by the clock period `CLK_NS`, and never less than one.

Reads keep chip-select and output-enable low for the full read window. The returned byte is registered on the last cycle of that window and handed back with a one-cycle done pulse. Writes are terminated by the write strobe. One setup cycle puts the address and data on the bus with the write strobe still high. The strobe then falls, and the write ends when chip-select and the write strobe rise together. After every access a recovery period keeps all strobes high and the driver off, so the memory's outputs can float before the next access. The client sees ready again only after that period.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and whenever the block is idle, chip-select, output-enable and write strobe are high (1), the data driver enable is 0 and ready is 1. The address output resets to 0.
- R2: A request is taken on a rising clock edge where valid and ready are both 1. Ready is 0 for exactly RD+TURN cycles after that edge, which is 36 cycles at the default 5 ns clock, for both reads and writes. Here RD = ceil(150/CLK_NS), WP = max(ceil(80/CLK_NS), ceil(150/CLK_NS)-1) and TURN = ceil(30/CLK_NS), each at least 1.
- R3: A read (write flag 0) holds chip-select and output-enable at 0 and the write strobe at 1 for RD cycles, starting in the cycle after acceptance. The driver enable stays 0.
- R4: The read byte is sampled at the clock edge that ends the read window. In the next cycle the done output is 1 for exactly one cycle, and the read-data output carries the byte and holds it until the next read finishes.
- R5: A write (write flag 1) spends one cycle with chip-select 0, write strobe 1 and the driver enabled. It then spends WP cycles with chip-select 0 and write strobe 0. Output-enable stays 1 throughout. Every write-strobe low pulse lasts at least 80 ns.
- R6: A write ends at a single edge that raises chip-select and the write strobe and disables the driver. Done is 1 in the cycle that follows, and the written byte is then stored at the address.
- R7: The address and write-data outputs change only at an edge where the write strobe is 1 both before and after. They hold the accepted values from acceptance through recovery.
- R8: The driver is enabled only while output-enable is 1. Its rising edge comes at least 30 ns after output-enable was last 0.
- R9: Valid, address, data and write-flag inputs presented while ready is 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Last read byte |
| mem_ce_no | output | 1 | Memory chip-select, active low |
| mem_oe_no | output | 1 | Memory output-enable, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Data driver enable (tristate control) |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The bound checker watches the strobe relationships on every cycle. It checks that strobes are quiet whenever ready is up, that the write strobe never falls outside chip-select, and that the driver never overlaps output-enable. It also checks the minimum widths of chip-select and write-strobe pulses, the float gap before driving, address stability around the write strobe, and that done lasts a single cycle. Exact cycle placement, read data correctness, read-after-write through a timing-aware memory stub, and the ignoring of requests while busy can only be shown by the bench's scenarios against its cycle-by-cycle reference model.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_WSETUP  = 3'd2,
    ST_WPULSE  = 3'd3,
    ST_RECOVER = 3'd4
  } st_e;

  function automatic int cdiv(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 30,
  parameter int WP_CYC   = 29,
  parameter int TURN_CYC = 6,
  parameter int CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             tmr_last_i,
  output st_e              state_q_o,
  output st_e              state_d_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  st_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        tmr_load_o = 1'b1;
        if (req_we_i) begin
          state_d   = ST_WSETUP;
          tmr_val_o = '0;
        end else begin
          state_d   = ST_READ;
          tmr_val_o = RD_LD;
        end
      end
      ST_READ: if (tmr_last_i) begin
        state_d    = ST_RECOVER;
        tmr_load_o = 1'b1;
        tmr_val_o  = TURN_LD;
      end
      ST_WSETUP: if (tmr_last_i) begin
        state_d    = ST_WPULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = WP_LD;
      end
      ST_WPULSE: if (tmr_last_i) begin
        state_d    = ST_RECOVER;
        tmr_load_o = 1'b1;
        tmr_val_o  = TURN_LD;
      end
      ST_RECOVER: if (tmr_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign accept_o  = (state_q == ST_IDLE) && req_valid_i;
endmodule

// File: rtl/sram_ctl_io.sv
`timescale 1ns/1ps
module sram_ctl_io
  import sram_ctl_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  st_e           state_q_i,
  input  st_e           state_d_i,
  input  logic          tmr_last_i,
  input  logic          accept_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  logic in_access_d, window_end;

  assign in_access_d = (state_d_i == ST_READ) || (state_d_i == ST_WSETUP) ||
                       (state_d_i == ST_WPULSE);
  assign window_end  = tmr_last_i &&
                       ((state_q_i == ST_READ) || (state_q_i == ST_WPULSE));

  // strobes come straight from flops, decoded from next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_n_o  <= !in_access_d;
      oe_n_o  <= !(state_d_i == ST_READ);
      we_n_o  <= !(state_d_i == ST_WPULSE);
      dq_oe_o <= (state_d_i == ST_WSETUP) || (state_d_i == ST_WPULSE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (accept_i) begin
      addr_o <= req_addr_i;
      dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= window_end;
      if (tmr_last_i && (state_q_i == ST_READ)) rdata_o <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS     = 5,
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int T_RC_NS    = 150,
  parameter int T_AA_NS    = 150,
  parameter int T_OE_NS    = 100,
  parameter int T_WP_NS    = 80,
  parameter int T_AW_NS    = 150,
  parameter int T_DW_NS    = 40,
  parameter int T_WC_NS    = 150,
  parameter int T_FLOAT_NS = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int RD_CYC = imax(1, cdiv(imax(T_RC_NS, imax(T_AA_NS, T_OE_NS)), CLK_NS));
  // setup cycle counts toward address/select/data windows
  localparam int WP_CYC = imax(1, imax(cdiv(T_WP_NS, CLK_NS),
                            imax(cdiv(T_AW_NS, CLK_NS) - 1,
                            imax(cdiv(T_DW_NS, CLK_NS) - 1,
                                 cdiv(T_WC_NS, CLK_NS) - 1))));
  localparam int TURN_CYC = imax(1, cdiv(T_FLOAT_NS, CLK_NS));
  localparam int MAX_CYC  = imax(RD_CYC, imax(WP_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  st_e              state_q, state_d;
  logic             tmr_load, tmr_last, accept;
  logic [CNT_W-1:0] tmr_val;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  sram_ctl_fsm #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .tmr_last_i  (tmr_last),
    .state_q_o   (state_q),
    .state_d_o   (state_d),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept)
  );

  sram_ctl_io #(.AW(AW), .DW(DW)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (state_q),
    .state_d_i   (state_d),
    .tmr_last_i  (tmr_last),
    .accept_i    (accept),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .ce_n_o      (mem_ce_no),
    .oe_n_o      (mem_oe_no),
    .we_n_o      (mem_we_no),
    .addr_o      (mem_addr_o),
    .dq_o        (mem_dq_o),
    .dq_oe_o     (mem_dq_oe_o),
    .rdata_o     (rsp_rdata_o),
    .done_o      (rsp_done_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int CLK_NS     = 5,
  parameter int AW         = 15,
  parameter int T_CE_NS    = 150,
  parameter int T_WP_NS    = 80,
  parameter int T_FLOAT_NS = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_i,
  input logic          done_i,
  input logic          ce_n_i,
  input logic          oe_n_i,
  input logic          we_n_i,
  input logic [AW-1:0] addr_i,
  input logic          dq_oe_i
);
  logic [15:0] oe_gap_q, we_low_q, ce_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_gap_q <= 16'hFFFF;
      we_low_q <= '0;
      ce_low_q <= '0;
    end else begin
      if (!oe_n_i)                   oe_gap_q <= '0;
      else if (oe_gap_q != 16'hFFFF) oe_gap_q <= oe_gap_q + 1'b1;
      we_low_q <= we_n_i ? 16'd0 : we_low_q + 1'b1;
      ce_low_q <= ce_n_i ? 16'd0 : ce_low_q + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (ce_n_i && oe_n_i && we_n_i && !dq_oe_i));

  p_busy_on_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_i |-> !ready_i);

  p_ce_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_i) |-> (int'(ce_low_q) * CLK_NS >= T_CE_NS));

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_we_inside_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> (!ce_n_i && oe_n_i));

  p_wp_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_i) |-> (int'(we_low_q) * CLK_NS >= T_WP_NS));

  p_we_end_drops_ce_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_i) |-> ce_n_i);

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_i) |-> (we_n_i && $past(we_n_i)));

  p_no_contend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i |-> oe_n_i);

  p_float_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_i) |-> (int'(oe_gap_q) * CLK_NS >= T_FLOAT_NS));
endmodule

bind sram_ctl sram_ctl_chk #(
  .CLK_NS     (CLK_NS),
  .AW         (AW),
  .T_CE_NS    (T_RC_NS),
  .T_WP_NS    (T_WP_NS),
  .T_FLOAT_NS (T_FLOAT_NS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (req_ready_o),
  .done_i  (rsp_done_o),
  .ce_n_i  (mem_ce_no),
  .oe_n_i  (mem_oe_no),
  .we_n_i  (mem_we_no),
  .addr_i  (mem_addr_o),
  .dq_oe_i (mem_dq_oe_o)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
  localparam int CLK = 5;
  localparam int RD_N   = (150 + CLK - 1) / CLK;
  localparam int WP_N   = (150 + CLK - 1) / CLK - 1;
  localparam int TURN_N = (30 + CLK - 1) / CLK;
  localparam int TOT_N  = RD_N + TURN_N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, done, ce_n, oe_n, we_n, dq_oe;
  logic [7:0] rdata, dq_o;
  logic [7:0] dq_i = 8'hxx;
  logic [14:0] maddr;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sram_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_done_o(done), .rsp_rdata_o(rdata),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // memory stub: data valid only after a full read window
  logic [7:0] mem [int];
  int rcnt = 0;
  bit prev_wlow = 0;
  logic [14:0] prev_a;
  logic [7:0]  prev_d;
  always @(negedge clk) begin
    if (prev_wlow && we_n) mem[int'(prev_a)] = prev_d;
    prev_wlow = !ce_n && !we_n;
    prev_a = maddr;
    prev_d = dq_oe ? dq_o : 8'hxx;
    if (!ce_n && !oe_n && we_n) rcnt++; else rcnt = 0;
    if (rcnt >= RD_N && mem.exists(int'(maddr))) dq_i = mem[int'(maddr)];
    else dq_i = 8'hxx;
  end

  // reference model
  logic [7:0] exp_mem [int];
  bit m_busy = 0, m_we = 0;
  int k = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rd = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; k = 0; m_addr = '0; m_wd = '0;
    end else if (!m_busy) begin
      if (valid) begin
        m_busy = 1; k = 1; m_we = we; m_addr = addr; m_wd = wdata;
        if (we) exp_mem[int'(addr)] = wdata;
      end
    end else if (k == TOT_N) m_busy = 0;
    else k++;
  end

  always @(negedge clk) begin
    bit e_ce, e_oe, e_we, e_drv, e_done;
    if (!rst_n) begin
      chk(ce_n && oe_n && we_n && !dq_oe && ready, "R1 reset strobes", {ce_n,oe_n,we_n,dq_oe,ready}, 5'b11101);
    end else begin
      e_ce = 1; e_oe = 1; e_we = 1; e_drv = 0; e_done = 0;
      if (m_busy) begin
        if (!m_we && k <= RD_N) begin e_ce = 0; e_oe = 0; end
        if (m_we && k == 1) begin e_ce = 0; e_drv = 1; end
        if (m_we && k >= 2 && k <= 1 + WP_N) begin e_ce = 0; e_we = 0; e_drv = 1; end
        e_done = (k == RD_N + 1);
      end
      chk(ready == !m_busy, m_busy ? "R2 ready low while busy" : "R1 ready idle", ready, !m_busy);
      chk(ce_n == e_ce, m_we ? "R5 chip select" : "R3 chip select", ce_n, e_ce);
      chk(oe_n == e_oe, m_we ? "R5 output enable" : "R3 output enable", oe_n, e_oe);
      chk(we_n == e_we, "R5 write strobe", we_n, e_we);
      chk(dq_oe == e_drv, "R8 driver enable", dq_oe, e_drv);
      chk(done == e_done, m_we ? "R6 done" : "R4 done", done, e_done);
      chk(maddr === m_addr, "R7 R9 address held", maddr, m_addr);
      if (e_drv) chk(dq_o === m_wd, "R7 write data", dq_o, m_wd);
      if (e_done && !m_we) begin
        m_rd = exp_mem.exists(int'(m_addr)) ? exp_mem[int'(m_addr)] : 8'hxx;
        chk(rdata === m_rd, "R4 read data", rdata, m_rd);
      end
      if (m_busy && !m_we && k == RD_N + 3)
        chk(rdata === m_rd, "R4 read data held", rdata, m_rd);
    end
  end

  task automatic req(input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready && ce_n && maddr == 15'd0, "R1 after reset", {ready, ce_n}, 2'b11);
    req(1, 15'h0000, 8'h5A);
    req(1, 15'h7FFF, 8'hA5);
    req(0, 15'h0000, 8'h00);
    req(0, 15'h7FFF, 8'h00);
    // back-to-back with garbage presented while busy
    req(1, 15'h1234, 8'hFF);
    for (int i = 0; i < 20; i++) begin
      valid = 1; we = i[0]; addr = 15'(i * 977); wdata = 8'(i * 37);
      @(negedge clk);
    end
    valid = 0;
    req(0, 15'h1234, 8'h00);
    req(1, 15'h4321, 8'h00);
    req(0, 15'h4321, 8'h00);
    req(1, 15'h0000, 8'hC3);
    req(0, 15'h0000, 8'h00);
    settle();
    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule